// File: doc/BRIEF.md
# Interrupt Entry and Return Stack Sequencer

This block produces the memory bus cycles that follow a CPU's decision to take an interrupt, and the bus cycles of the matching return. On entry it saves the interrupted program counter and the status byte on a downward-growing stack. The stack lives in one of two 256-byte pages. The block then reads a two-byte vector and hands the new program counter back to the core. On return it reads the three saved bytes back in reverse order and restores the program counter and the status byte.

The core starts either operation with a one-cycle pulse. Along with the pulse it supplies the current program counter, status byte, stack offset, page select bit and the address of the vector. All of these are captured at acceptance. The block drives an 8-bit data bus with separate read and write strobes. It marks the opcode fetch of the first instruction that follows. It raises a done pulse in the cycle where the new program counter, stack offset and status byte are valid. Stack offsets wrap within the 8-bit page offset.

Top module: `irq_stack_seq`

## Requirements
- R1: Out of reset, and whenever no operation is running, `bus_re`, `bus_we`, `fetch_mark` and `seq_done` are all 0.
- R2: An accepted entry lasts exactly 7 cycles, starting in the cycle after the start pulse is sampled. The first of these cycles is a bus cycle with neither strobe, on the address of the captured program counter.
- R3: Entry cycles 2, 3 and 4 are writes with `bus_we` = 1. They write the program counter high byte to offset S, the low byte to S-1 and the status byte to S-2. Offsets are taken modulo 256.
- R4: Every stack address has high byte 0x00 when the page select bit is 0 and 0x01 when it is 1. The offset sits in the low byte.
- R5: Entry cycles 5 and 6 are reads with `bus_re` = 1, at the vector address and at the vector address plus 1. The byte read first becomes the low byte of the new program counter, and the byte read second becomes the high byte.
- R6: Entry cycle 7 asserts `bus_re`, `fetch_mark` and `seq_done` at the new program counter address. In that cycle `new_pc` holds the vector, `new_sp` holds S-3 modulo 256 and `new_ps` holds the pushed status byte.
- R7: An accepted return lasts exactly 5 cycles. The first is a no-strobe cycle at offset S. Then come reads of the status byte at S+1, the program counter low byte at S+2 and the program counter high byte at S+3. The last cycle asserts `bus_re`, `fetch_mark` and `seq_done` at the restored program counter, with `new_sp` = S+3 modulo 256 and `new_ps` holding the restored status byte.
- R8: A start pulse of either kind is ignored while an operation is running, including in its done cycle. A start pulse in the cycle right after the done cycle is accepted.
- R9: When entry and return start pulses arrive in the same cycle, the entry is performed.
- R10: `bus_re` and `bus_we` are never both 1, and `fetch_mark` is 1 only together with `bus_re`.
- R11: Changes to the program counter, status, stack offset, page select and vector inputs after acceptance do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_entry | input | 1 | One-cycle request to run the interrupt entry sequence |
| start_return | input | 1 | One-cycle request to run the return sequence |
| vec_addr | input | 16 | Address of the vector low byte |
| pc_in | input | 16 | Program counter to be saved |
| ps_in | input | 8 | Status byte to be saved |
| sp_in | input | 8 | Current stack offset S |
| stack_page | input | 1 | Stack page select: 0 for page 0x00, 1 for page 0x01 |
| bus_rdata | input | 8 | Read data, valid in the same cycle as `bus_re` |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data, valid while `bus_we` is 1 |
| bus_re | output | 1 | Read strobe |
| bus_we | output | 1 | Write strobe |
| fetch_mark | output | 1 | Marks the opcode fetch of the next instruction |
| seq_done | output | 1 | One-cycle pulse: `new_pc`, `new_sp` and `new_ps` are valid |
| new_pc | output | 16 | Program counter after the operation |
| new_sp | output | 8 | Stack offset after the operation |
| new_ps | output | 8 | Status byte after the operation |

## Verification
Entries are run with a stack offset high in page 0 and with offset 0x01 in page 1. The second case forces the status push and the final offset to wrap, which separates modulo-256 offset arithmetic from a carry into the page byte. Each entry is paired with a return at the matching offset. The return at 0xFE in page 1 reads across the wrap, so the byte order and the page are both confirmed by the values that come back. Start pulses are injected during a running entry, on its done cycle, and together with changed operand inputs, which checks both that starts are ignored while busy and that operands are captured at acceptance. Simultaneous entry and return pulses check the priority, and a return issued on the cycle after a done checks that back-to-back operations are accepted.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_GAP,
    S_EN_PCH,
    S_EN_PCL,
    S_EN_PS,
    S_EN_VLO,
    S_EN_VHI,
    S_EN_JMP,
    S_RT_GAP,
    S_RT_PS,
    S_RT_PCL,
    S_RT_PCH,
    S_RT_JMP
  } seq_st_e;

endpackage

// File: rtl/irq_seq_rst_sync.sv
module irq_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= (chain_q << 1) | STAGES'(1);
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_entry,
  input  logic    start_return,
  output seq_st_e st_q,
  output logic    load_en
);

  seq_st_e st_d;

  // next state; starts are only looked at in S_IDLE
  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_entry) begin
          st_d    = S_EN_GAP;
          load_en = 1'b1;
        end else if (start_return) begin
          st_d    = S_RT_GAP;
          load_en = 1'b1;
        end
      end
      S_EN_GAP: st_d = S_EN_PCH;
      S_EN_PCH: st_d = S_EN_PCL;
      S_EN_PCL: st_d = S_EN_PS;
      S_EN_PS:  st_d = S_EN_VLO;
      S_EN_VLO: st_d = S_EN_VHI;
      S_EN_VHI: st_d = S_EN_JMP;
      S_EN_JMP: st_d = S_IDLE;
      S_RT_GAP: st_d = S_RT_PS;
      S_RT_PS:  st_d = S_RT_PCL;
      S_RT_PCL: st_d = S_RT_PCH;
      S_RT_PCH: st_d = S_RT_JMP;
      S_RT_JMP: st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/irq_seq_datapath.sv
module irq_seq_datapath
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           st_q,
  input  logic              load_en,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] ps_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic              page_in,
  input  logic [PC_W-1:0]   vec_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [PC_W-1:0]   addr,
  output logic [DATA_W-1:0] wdata,
  output logic              re,
  output logic              we,
  output logic              mark,
  output logic              done,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] ps_o
);

  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] ps_q;
  logic [DATA_W-1:0] sp_q;
  logic              page_q;
  logic [PC_W-1:0]   vec_q;

  logic              pc_lo_en, pc_hi_en, ps_en;
  logic [DATA_W-1:0] pc_lo_d, pc_hi_d, ps_d;

  function automatic logic [PC_W-1:0] stk(input logic pg, input logic [DATA_W-1:0] off);
    return {{(DATA_W-1){1'b0}}, pg, off};
  endfunction

  // clock enables and next values
  always_comb begin
    pc_lo_en = load_en || (st_q == S_EN_VLO) || (st_q == S_RT_PCL);
    pc_hi_en = load_en || (st_q == S_EN_VHI) || (st_q == S_RT_PCH);
    ps_en    = load_en || (st_q == S_RT_PS);
    pc_lo_d  = load_en ? pc_in[DATA_W-1:0]    : rdata;
    pc_hi_d  = load_en ? pc_in[PC_W-1:DATA_W] : rdata;
    ps_d     = load_en ? ps_in                : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ps_q   <= '0;
      sp_q   <= '0;
      page_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (pc_lo_en) pc_q[DATA_W-1:0]    <= pc_lo_d;
      if (pc_hi_en) pc_q[PC_W-1:DATA_W] <= pc_hi_d;
      if (ps_en)    ps_q                <= ps_d;
      if (load_en) begin
        sp_q   <= sp_in;
        page_q <= page_in;
        vec_q  <= vec_in;
      end
    end
  end

  // bus cycle decode
  always_comb begin
    addr  = pc_q;
    wdata = '0;
    re    = 1'b0;
    we    = 1'b0;
    mark  = 1'b0;
    done  = 1'b0;
    unique case (st_q)
      S_EN_PCH: begin
        addr  = stk(page_q, sp_q);
        wdata = pc_q[PC_W-1:DATA_W];
        we    = 1'b1;
      end
      S_EN_PCL: begin
        addr  = stk(page_q, sp_q - DATA_W'(1));
        wdata = pc_q[DATA_W-1:0];
        we    = 1'b1;
      end
      S_EN_PS: begin
        addr  = stk(page_q, sp_q - DATA_W'(2));
        wdata = ps_q;
        we    = 1'b1;
      end
      S_EN_VLO: begin
        addr = vec_q;
        re   = 1'b1;
      end
      S_EN_VHI: begin
        addr = vec_q + PC_W'(1);
        re   = 1'b1;
      end
      S_EN_JMP, S_RT_JMP: begin
        re   = 1'b1;
        mark = 1'b1;
        done = 1'b1;
      end
      S_RT_GAP: addr = stk(page_q, sp_q);
      S_RT_PS: begin
        addr = stk(page_q, sp_q + DATA_W'(1));
        re   = 1'b1;
      end
      S_RT_PCL: begin
        addr = stk(page_q, sp_q + DATA_W'(2));
        re   = 1'b1;
      end
      S_RT_PCH: begin
        addr = stk(page_q, sp_q + DATA_W'(3));
        re   = 1'b1;
      end
      default: ;
    endcase
  end

  assign pc_o = pc_q;
  assign ps_o = ps_q;
  assign sp_o = (st_q == S_RT_JMP) ? sp_q + DATA_W'(3) : sp_q - DATA_W'(3);

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RST_SYNC = 2,
  localparam int unsigned PC_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_entry,
  input  logic              start_return,
  input  logic [PC_W-1:0]   vec_addr,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] ps_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic              stack_page,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [PC_W-1:0]   bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_re,
  output logic              bus_we,
  output logic              fetch_mark,
  output logic              seq_done,
  output logic [PC_W-1:0]   new_pc,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_ps
);

  logic    rst_n_core;
  seq_st_e st_q;
  logic    load_en;

  irq_seq_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_core)
  );

  irq_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_core),
    .start_entry  (start_entry),
    .start_return (start_return),
    .st_q         (st_q),
    .load_en      (load_en)
  );

  irq_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .st_q    (st_q),
    .load_en (load_en),
    .pc_in   (pc_in),
    .ps_in   (ps_in),
    .sp_in   (sp_in),
    .page_in (stack_page),
    .vec_in  (vec_addr),
    .rdata   (bus_rdata),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .re      (bus_re),
    .we      (bus_we),
    .mark    (fetch_mark),
    .done    (seq_done),
    .pc_o    (new_pc),
    .sp_o    (new_sp),
    .ps_o    (new_ps)
  );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PC_W  = 2 * DATA_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] bus_addr,
  input logic            bus_re,
  input logic            bus_we,
  input logic            fetch_mark,
  input logic            seq_done
);

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && bus_we));

  a_r10_mark_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_mark |-> bus_re);

  a_r6_done_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (fetch_mark && bus_re));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r3_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we)) |->
      (bus_addr[DATA_W-1:0] == $past(bus_addr[DATA_W-1:0]) - DATA_W'(1)));

  a_r4_push_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_addr[PC_W-1:DATA_W+1] == '0));

  a_r5_push_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (bus_we || bus_re));

endmodule

bind irq_stack_seq irq_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_re     (bus_re),
  .bus_we     (bus_we),
  .fetch_mark (fetch_mark),
  .seq_done   (seq_done)
);

// File: tb/irq_stack_seq_tb.sv
module irq_stack_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        start_entry, start_return;
  logic [15:0] vec_addr, pc_in;
  logic [7:0]  ps_in, sp_in;
  logic        stack_page;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_re, bus_we, fetch_mark, seq_done;
  logic [15:0] new_pc;
  logic [7:0]  new_sp, new_ps;

  int n_cmp;
  int n_bad;
  string ctx;

  irq_stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .start_return(start_return),
    .vec_addr(vec_addr), .pc_in(pc_in), .ps_in(ps_in), .sp_in(sp_in),
    .stack_page(stack_page), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_we(bus_we), .fetch_mark(fetch_mark),
    .seq_done(seq_done), .new_pc(new_pc), .new_sp(new_sp), .new_ps(new_ps)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bus-side memory seen by the design, and the model's own copy
  logic [7:0] smem [0:511];
  logic [7:0] vmem [0:15];
  logic [7:0] rsmem [0:511];
  logic [7:0] rvmem [0:15];

  assign bus_rdata = (bus_addr[15:9] == 7'd0) ? smem[bus_addr[8:0]] :
                     (bus_addr[15:4] == 12'hFFF) ? vmem[bus_addr[3:0]] : 8'h00;

  always @(posedge clk) begin
    if (bus_we && bus_addr[15:9] == 7'd0) smem[bus_addr[8:0]] <= bus_wdata;
  end

  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    if (a[15:9] == 7'd0) return rsmem[a[8:0]];
    if (a[15:4] == 12'hFFF) return rvmem[a[3:0]];
    return 8'h00;
  endfunction

  // expected cycle queues
  logic [15:0] q_addr [$];
  logic [7:0]  q_wd   [$];
  logic [3:0]  q_ctl  [$];   // {re, we, mark, done}
  logic [15:0] q_pc   [$];
  logic [7:0]  q_sp   [$];
  logic [7:0]  q_ps   [$];
  string       q_tag  [$];

  function automatic void push_cyc(input logic [15:0] a, input logic [7:0] wd, input logic [3:0] c,
                                   input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] ps,
                                   input string t);
    q_addr.push_back(a); q_wd.push_back(wd); q_ctl.push_back(c);
    q_pc.push_back(pc); q_sp.push_back(sp); q_ps.push_back(ps);
    q_tag.push_back({t, ctx});
  endfunction

  function automatic void model_entry(input logic [15:0] pc, input logic [7:0] ps, input logic [7:0] sp,
                                      input logic pg, input logic [15:0] v);
    logic [15:0] base;
    logic [7:0]  o1, o2;
    logic [15:0] npc;
    base = pg ? 16'h0100 : 16'h0000;
    o1 = sp - 8'd1;
    o2 = sp - 8'd2;
    push_cyc(pc, 8'h00, 4'b0000, 16'h0, 8'h0, 8'h0, "R2 entry gap");
    push_cyc(base | {8'h00, sp}, pc[15:8], 4'b0100, 16'h0, 8'h0, 8'h0, "R3 push PCH");
    push_cyc(base | {8'h00, o1}, pc[7:0],  4'b0100, 16'h0, 8'h0, 8'h0, "R3 push PCL");
    push_cyc(base | {8'h00, o2}, ps,       4'b0100, 16'h0, 8'h0, 8'h0, "R3 push PS");
    rsmem[{pg, sp}] = pc[15:8];
    rsmem[{pg, o1}] = pc[7:0];
    rsmem[{pg, o2}] = ps;
    push_cyc(v,          8'h00, 4'b1000, 16'h0, 8'h0, 8'h0, "R5 vec lo");
    push_cyc(v + 16'd1,  8'h00, 4'b1000, 16'h0, 8'h0, 8'h0, "R5 vec hi");
    npc = {ref_rd(v + 16'd1), ref_rd(v)};
    push_cyc(npc, 8'h00, 4'b1011, npc, sp - 8'd3, ps, "R6 entry fetch");
  endfunction

  function automatic void model_return(input logic [7:0] sp, input logic pg);
    logic [15:0] base;
    logic [7:0]  o1, o2, o3;
    logic [15:0] npc;
    base = pg ? 16'h0100 : 16'h0000;
    o1 = sp + 8'd1; o2 = sp + 8'd2; o3 = sp + 8'd3;
    push_cyc(base | {8'h00, sp}, 8'h00, 4'b0000, 16'h0, 8'h0, 8'h0, "R7 return gap");
    push_cyc(base | {8'h00, o1}, 8'h00, 4'b1000, 16'h0, 8'h0, 8'h0, "R7 pop PS");
    push_cyc(base | {8'h00, o2}, 8'h00, 4'b1000, 16'h0, 8'h0, 8'h0, "R7 pop PCL");
    push_cyc(base | {8'h00, o3}, 8'h00, 4'b1000, 16'h0, 8'h0, 8'h0, "R7 pop PCH");
    npc = {rsmem[{pg, o3}], rsmem[{pg, o2}]};
    push_cyc(npc, 8'h00, 4'b1011, npc, o3, rsmem[{pg, o1}], "R7 return fetch");
  endfunction

  // model step: the cycle ending at this edge leaves the queue; a start is taken only when idle
  int qn;
  always @(posedge clk) begin
    if (rst_n) begin
      qn = q_ctl.size();
      if (qn != 0) begin
        void'(q_addr.pop_front()); void'(q_wd.pop_front()); void'(q_ctl.pop_front());
        void'(q_pc.pop_front()); void'(q_sp.pop_front()); void'(q_ps.pop_front());
        void'(q_tag.pop_front());
      end else if (start_entry) begin
        model_entry(pc_in, ps_in, sp_in, stack_page, vec_addr);
      end else if (start_return) begin
        model_return(sp_in, stack_page);
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10", "strobe exclusion", {31'd0, (bus_re && bus_we) || (fetch_mark && !bus_re)}, 32'd0);
      if (q_ctl.size() != 0) begin
        check(q_tag[0], "ctl", {28'd0, bus_re, bus_we, fetch_mark, seq_done}, {28'd0, q_ctl[0]});
        check(q_tag[0], "addr", {16'd0, bus_addr}, {16'd0, q_addr[0]});
        if (q_ctl[0][2]) check(q_tag[0], "wdata", {24'd0, bus_wdata}, {24'd0, q_wd[0]});
        if (q_ctl[0][0]) begin
          check(q_tag[0], "new_pc", {16'd0, new_pc}, {16'd0, q_pc[0]});
          check(q_tag[0], "new_sp", {24'd0, new_sp}, {24'd0, q_sp[0]});
          check(q_tag[0], "new_ps", {24'd0, new_ps}, {24'd0, q_ps[0]});
        end
      end else begin
        check({"R1 idle", ctx}, "ctl", {28'd0, bus_re, bus_we, fetch_mark, seq_done}, 32'd0);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: cycles %0d expected below %0d", 200000, 200000);
    summary();
    $finish;
  end

  task automatic set_ops(input logic [15:0] pc, input logic [7:0] ps, input logic [7:0] sp,
                         input logic pg, input logic [15:0] v);
    pc_in = pc; ps_in = ps; sp_in = sp; stack_page = pg; vec_addr = v;
  endtask

  task automatic do_entry(input logic [15:0] pc, input logic [7:0] ps, input logic [7:0] sp,
                          input logic pg, input logic [15:0] v, input int gap);
    @(negedge clk);
    set_ops(pc, ps, sp, pg, v);
    start_entry = 1'b1;
    @(negedge clk);
    start_entry = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_return(input logic [7:0] sp, input logic pg, input int gap);
    @(negedge clk);
    sp_in = sp; stack_page = pg;
    start_return = 1'b1;
    @(negedge clk);
    start_return = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; ctx = "";
    for (int i = 0; i < 512; i++) begin smem[i] = 8'hEE; rsmem[i] = 8'hEE; end
    for (int i = 0; i < 16; i++) begin
      vmem[i] = 8'(8'h31 + i * 13); rvmem[i] = 8'(8'h31 + i * 13);
    end
    rst_n = 1'b0; start_entry = 1'b0; start_return = 1'b0;
    set_ops(16'h0, 8'h0, 8'h0, 1'b0, 16'hFFF0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // page 0, offset high in the page
    do_entry(16'h1234, 8'hA5, 8'hFF, 1'b0, 16'hFFFA, 8);
    do_return(8'hFC, 1'b0, 6);

    // page 1 with offset wrap on push and pop
    ctx = " R4";
    do_entry(16'hBEEF, 8'h3C, 8'h01, 1'b1, 16'hFFF4, 8);
    do_return(8'hFE, 1'b1, 6);

    // starts while busy, operand inputs changing mid-sequence
    ctx = " R8 R11";
    @(negedge clk);
    set_ops(16'h4567, 8'h81, 8'h80, 1'b0, 16'hFFF0);
    start_entry = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      start_entry = 1'b0; start_return = 1'b0;
      if (k == 2 || k == 4) begin
        start_entry = 1'b1; set_ops(16'h9999, 8'h11, 8'h20, 1'b1, 16'hFFF8);
      end
      if (k == 3 || k == 7) start_return = 1'b1;
    end
    start_entry = 1'b0; start_return = 1'b0;
    repeat (6) @(negedge clk);

    // simultaneous starts: entry wins
    ctx = " R9";
    @(negedge clk);
    set_ops(16'h0F0E, 8'h5A, 8'h40, 1'b1, 16'hFFF2);
    start_entry = 1'b1; start_return = 1'b1;
    @(negedge clk);
    start_entry = 1'b0; start_return = 1'b0;
    repeat (6) @(negedge clk);

    // return started on the cycle right after done
    ctx = " R8";
    do_return(8'h3D, 1'b1, 8);

    summary();
    $finish;
  end

endmodule